// File: doc/BRIEF.md
# Single-Instruction Interrupt Counter Unit

This unit services an interrupt level whose vector slot holds a modify-and-test instruction. When a level is activated, the core hands over the fetched vector instruction: an opcode, an operand size, a signed increment and an effective address. If the opcode is the modify-and-test opcode and the size is legal, the unit performs one read-modify-write of a byte, halfword or word through a synchronous memory port. It then clears and re-arms the level in a single cycle and pulses `done`, so that the interrupted program resumes. The only delay the program sees is the time taken by this one update.

The update has no side effects beyond the memory write. No flag records an overflow, and there is no protection check that could trap. The effective address is used as a physical address. The one exception is the designated mapped counter level: while mapping is enabled, its address goes through an external translate port. For count-pulse levels, a zero result raises a counter-equals-zero request. When the opcode is not modify-and-test, the unit leaves memory and the level alone and flags `not_single`, so that ordinary interrupt entry takes over.

Top module: `sii_counter_unit`

## Requirements
- R1: An accepted activation (idle, `lvl_act`=1, `vec_op`=8'h33, `vec_size`≠2'b11) gives `mem_rd` for exactly one cycle in the cycle after the accepting edge. `mem_wr` follows for one cycle two cycles later. `busy` is high from the read cycle through the done cycle.
- R2: Size 2'b00 (byte): the written value is (old + increment) mod 2^8, and `mem_wdata` bits above bit 7 are zero. Overflow just wraps.
- R3: Sizes 2'b01 (halfword, 16 bits) and 2'b10 (word, 32 bits) wrap modulo their widths. `mem_size` equals the requested size during the read and the write.
- R4: The 8-bit increment is two's complement and is sign-extended to the operand width.
- R5: For any level other than 4, `mem_addr` equals `vec_addr`, whether `map_en` is set or not.
- R6: For level 4 with `map_en`=1, `mem_addr` equals `xlat_paddr`, the translation of `xlat_vaddr`=`vec_addr`. For level 4 with `map_en`=0, `mem_addr` equals `vec_addr`.
- R7: `done`, `lvl_clear` and `lvl_arm` pulse together for one cycle, in the cycle after the write cycle. The unit is idle in the cycle after that.
- R8: `zero_req` pulses with `done` only when `cnt_pulse` was set at activation and the result is zero.
- R9: An activation with any other opcode, or with size 2'b11, raises `not_single` in that same cycle. It causes no memory access and no `lvl_clear`, `lvl_arm` or `done`.
- R10: `lvl_act` and vector fields presented while the unit is busy are ignored. No second access follows the `done` pulse.
- R11: After reset, `busy`, `mem_rd`, `mem_wr`, `done`, `lvl_clear`, `lvl_arm` and `zero_req` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lvl_act | input | 1 | Interrupt level activation |
| lvl_id | input | LVL_W | Number of the activated level |
| cnt_pulse | input | 1 | Activated level is a count-pulse level |
| map_en | input | 1 | Mapping enabled in the status word |
| vec_op | input | 8 | Opcode fetched from the vector slot |
| vec_size | input | 2 | Operand size: 00 byte, 01 halfword, 10 word |
| vec_inc | input | INC_W | Signed increment |
| vec_addr | input | AW | Effective address |
| busy | output | 1 | Update in progress |
| not_single | output | 1 | Vector is not a modify-and-test instruction |
| xlat_vaddr | output | AW | Address offered for translation |
| xlat_paddr | input | AW | Translated address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory address |
| mem_size | output | 2 | Access size, same encoding as vec_size |
| mem_wdata | output | 32 | Right-justified write data |
| mem_rdata | input | 32 | Right-justified read data, valid one cycle after mem_rd |
| lvl_clear | output | 1 | Clear the serviced level |
| lvl_arm | output | 1 | Re-arm the serviced level |
| done | output | 1 | Update finished, program resumes |
| zero_req | output | 1 | Counter-equals-zero request |

## Verification
The update is tried with a byte that carries out (FF+1) and a byte that crosses the sign boundary (7F+1). These separate true modulo wrapping from saturation or from a trap. A halfword with a negative increment and a word at all-ones show whether sign extension matches the operand width. The same increment is applied with and without `cnt_pulse`, and level 4 is run with and without mapping next to another level with mapping on. Each pair differs in one cause only, so a wrong condition for the zero request or for the address choice shows up.

// File: rtl/sii_pkg.sv
package sii_pkg;
  localparam int DW = 32;

  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_READ   = 3'd1,
    S_MODIFY = 3'd2,
    S_WRITE  = 3'd3,
    S_CLRARM = 3'd4
  } sii_state_e;

  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_HALF = 2'b01;
  localparam logic [1:0] SZ_WORD = 2'b10;
  localparam logic [1:0] SZ_BAD  = 2'b11;

  // Lane mask for a right-justified operand of the given size
  function automatic logic [DW-1:0] size_mask(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: size_mask = {{(DW-8){1'b0}}, 8'hFF};
      SZ_HALF: size_mask = {{(DW/2){1'b0}}, {(DW/2){1'b1}}};
      default: size_mask = {DW{1'b1}};
    endcase
  endfunction

  // Two's complement add that wraps at the operand width
  function automatic logic [DW-1:0] wrap_add(input logic [DW-1:0] old_v,
                                             input logic [DW-1:0] inc_v,
                                             input logic [1:0]    sz);
    wrap_add = (old_v + inc_v) & size_mask(sz);
  endfunction

  function automatic logic is_zero(input logic [DW-1:0] v, input logic [1:0] sz);
    is_zero = ((v & size_mask(sz)) == '0);
  endfunction
endpackage

// File: rtl/sii_seq.sv
module sii_seq
  import sii_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  output sii_state_e state
);
  sii_state_e nxt;

  always_comb begin
    nxt = state;
    case (state)
      S_IDLE:   if (start) nxt = S_READ;
      S_READ:   nxt = S_MODIFY;
      S_MODIFY: nxt = S_WRITE;
      S_WRITE:  nxt = S_CLRARM;
      S_CLRARM: nxt = S_IDLE;
      default:  nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/sii_modify.sv
module sii_modify
  import sii_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] rdata,
  input  logic [DW-1:0] inc_ext,
  input  logic [1:0]    size,
  output logic [DW-1:0] result,
  output logic          result_zero
);
  logic [DW-1:0] sum;
  assign sum = wrap_add(rdata & size_mask(size), inc_ext, size);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result      <= '0;
      result_zero <= 1'b0;
    end else if (load) begin
      result      <= sum;
      result_zero <= is_zero(sum, size);
    end
  end
endmodule

// File: rtl/sii_addr_sel.sv
module sii_addr_sel #(
  parameter int AW = 16
) (
  input  logic          use_map,
  input  logic [AW-1:0] eff_addr,
  input  logic [AW-1:0] xlat_paddr,
  output logic [AW-1:0] xlat_vaddr,
  output logic [AW-1:0] phys_addr
);
  assign xlat_vaddr = eff_addr;
  assign phys_addr  = use_map ? xlat_paddr : eff_addr;
endmodule

// File: rtl/sii_counter_unit.sv
module sii_counter_unit
  import sii_pkg::*;
#(
  parameter int          AW         = 16,
  parameter int          LVL_W      = 4,
  parameter int          INC_W      = 8,
  parameter int          MAPPED_LVL = 4,
  parameter logic [7:0]  MT_OP      = 8'h33
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lvl_act,
  input  logic [LVL_W-1:0] lvl_id,
  input  logic             cnt_pulse,
  input  logic             map_en,
  input  logic [7:0]       vec_op,
  input  logic [1:0]       vec_size,
  input  logic [INC_W-1:0] vec_inc,
  input  logic [AW-1:0]    vec_addr,
  output logic             busy,
  output logic             not_single,
  output logic [AW-1:0]    xlat_vaddr,
  input  logic [AW-1:0]    xlat_paddr,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic [AW-1:0]    mem_addr,
  output logic [1:0]       mem_size,
  output logic [31:0]      mem_wdata,
  input  logic [31:0]      mem_rdata,
  output logic             lvl_clear,
  output logic             lvl_arm,
  output logic             done,
  output logic             zero_req
);
  localparam int EXT_W = DW - INC_W;
  localparam logic [LVL_W-1:0] MAP_ID = LVL_W'(MAPPED_LVL);

  sii_state_e state;
  logic       idle, is_mt, start;
  logic [AW-1:0]    addr_q;
  logic [1:0]       size_q;
  logic [DW-1:0]    inc_q;
  logic [LVL_W-1:0] lvl_q;
  logic             map_q, cp_q;
  logic [DW-1:0]    result;
  logic             result_zero;
  logic             use_map;

  // Named events for the checker
  logic ev_accept, ev_reject;

  assign idle       = (state == S_IDLE);
  assign is_mt      = (vec_op == MT_OP) && (vec_size != SZ_BAD);
  assign start      = idle && lvl_act && is_mt;
  assign ev_accept  = start;
  assign ev_reject  = idle && lvl_act && !is_mt;
  assign not_single = ev_reject;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      size_q <= SZ_BYTE;
      inc_q  <= '0;
      lvl_q  <= '0;
      map_q  <= 1'b0;
      cp_q   <= 1'b0;
    end else if (start) begin
      addr_q <= vec_addr;
      size_q <= vec_size;
      inc_q  <= {{EXT_W{vec_inc[INC_W-1]}}, vec_inc};
      lvl_q  <= lvl_id;
      map_q  <= map_en;
      cp_q   <= cnt_pulse;
    end
  end

  sii_seq u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .state (state)
  );

  sii_modify u_mod (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (state == S_MODIFY),
    .rdata       (mem_rdata),
    .inc_ext     (inc_q),
    .size        (size_q),
    .result      (result),
    .result_zero (result_zero)
  );

  assign use_map = map_q && (lvl_q == MAP_ID);

  sii_addr_sel #(.AW(AW)) u_addr (
    .use_map    (use_map),
    .eff_addr   (addr_q),
    .xlat_paddr (xlat_paddr),
    .xlat_vaddr (xlat_vaddr),
    .phys_addr  (mem_addr)
  );

  assign busy      = !idle;
  assign mem_rd    = (state == S_READ);
  assign mem_wr    = (state == S_WRITE);
  assign mem_size  = size_q;
  assign mem_wdata = result;
  assign done      = (state == S_CLRARM);
  assign lvl_clear = done;
  assign lvl_arm   = done;
  assign zero_req  = done && cp_q && result_zero;
endmodule

// File: rtl/sii_chk.sv
module sii_chk
  import sii_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        mem_rd,
  input logic        mem_wr,
  input logic [1:0]  mem_size,
  input logic [31:0] mem_wdata,
  input logic        done,
  input logic        lvl_clear,
  input logic        lvl_arm,
  input logic        zero_req,
  input logic        busy,
  input logic        ev_accept,
  input logic        ev_reject
);
  a_r1_rd_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> mem_rd);
  a_r1_wr_after_rd: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_wr) |-> $past(mem_rd, 2));
  a_r1_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd, mem_wr, done}));
  a_r2_wdata_fits: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> ((mem_wdata & ~size_mask(mem_size)) == '0));
  a_r7_done_after_wr: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lvl_clear && lvl_arm && $past(mem_wr)));
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);
  a_r8_zero_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    zero_req |-> done);
  a_r9_reject_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ev_reject |=> !mem_rd && !busy);
endmodule

bind sii_counter_unit sii_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_rd    (mem_rd),
  .mem_wr    (mem_wr),
  .mem_size  (mem_size),
  .mem_wdata (mem_wdata),
  .done      (done),
  .lvl_clear (lvl_clear),
  .lvl_arm   (lvl_arm),
  .zero_req  (zero_req),
  .busy      (busy),
  .ev_accept (ev_accept),
  .ev_reject (ev_reject)
);

// File: tb/sim_sii_counter_unit.sv
module sim_sii_counter_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lvl_act = 1'b0;
  logic [3:0]  lvl_id = '0;
  logic        cnt_pulse = 1'b0;
  logic        map_en = 1'b0;
  logic [7:0]  vec_op = '0;
  logic [1:0]  vec_size = '0;
  logic [7:0]  vec_inc = '0;
  logic [15:0] vec_addr = '0;
  logic        busy, not_single, mem_rd, mem_wr, lvl_clear, lvl_arm, done, zero_req;
  logic [15:0] xlat_vaddr, xlat_paddr, mem_addr;
  logic [1:0]  mem_size;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;

  int nchk = 0;
  int nerr = 0;
  bit finished = 0;
  longint mem [int];

  always #5 clk = ~clk;

  assign xlat_paddr = xlat_vaddr ^ 16'h0100;

  sii_counter_unit u0 (.*);

  function automatic longint wmask(int sz);
    return (sz == 0) ? 64'hFF : (sz == 1) ? 64'hFFFF : 64'hFFFF_FFFF;
  endfunction

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem.exists(int'(mem_addr)) ? 32'(mem[int'(mem_addr)]) : 32'h0;
    if (mem_wr) mem[int'(mem_addr)] = longint'(mem_wdata) & wmask(int'(mem_size));
  end

  task automatic chk(string req, longint act, longint exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Behavioural expectation of one full update, checked every cycle
  task automatic txn(int lvl, bit cp, bit men, int sz, int inc, int addr,
                     longint init, bit hold);
    longint m = wmask(sz) + 1;
    longint res = ((init + inc) % m + m) % m;
    int ea = (lvl == 4 && men) ? (addr ^ 'h100) : addr;
    mem[ea] = init;
    lvl_act = 1; lvl_id = 4'(lvl); cnt_pulse = cp; map_en = men;
    vec_op = 8'h33; vec_size = 2'(sz); vec_inc = 8'(inc); vec_addr = 16'(addr);
    #1 chk("R9 not_single on valid op", not_single, 0);
    @(negedge clk);
    if (hold) begin vec_addr = 16'h7777; vec_size = 2'b00; end
    else lvl_act = 0;
    chk("R1 read strobe", mem_rd, 1);
    chk("R1 busy", busy, 1);
    chk("R5/R6 address", mem_addr, ea);
    chk("R6 vaddr", xlat_vaddr, addr);
    chk("R3 mem_size", mem_size, sz);
    @(negedge clk);
    chk("R1 idle strobe", mem_rd | mem_wr | done, 0);
    @(negedge clk);
    lvl_act = 0;
    chk("R1 write strobe", mem_wr, 1);
    chk("R5/R6 write address", mem_addr, ea);
    chk("R2/R3/R4 wdata", mem_wdata, res);
    @(negedge clk);
    chk("R7 done", done, 1);
    chk("R7 clear", lvl_clear, 1);
    chk("R7 arm", lvl_arm, 1);
    chk("R8 zero_req", zero_req, (cp && res == 0));
    chk("R2/R3 memory", mem[ea], res);
    @(negedge clk);
    chk("R7 idle after done", busy | done, 0);
    chk("R10 no second read", mem_rd, 0);
    @(negedge clk);
    chk("R10 no second access", mem_rd | mem_wr, 0);
  endtask

  task automatic reject(logic [7:0] op, logic [1:0] sz);
    mem[16'h0040] = 64'h55;
    lvl_act = 1; vec_op = op; vec_size = sz; vec_addr = 16'h0040; vec_inc = 8'h01;
    #1 chk("R9 not_single raised", not_single, 1);
    @(negedge clk);
    lvl_act = 0;
    chk("R9 stays idle", busy, 0);
    chk("R9 no read", mem_rd, 0);
    @(negedge clk);
    chk("R9 no clear/arm", lvl_clear | lvl_arm | done, 0);
    chk("R9 memory untouched", mem[16'h0040], 64'h55);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 busy", busy, 0);
    chk("R11 strobes", mem_rd | mem_wr, 0);
    chk("R11 level outputs", done | lvl_clear | lvl_arm | zero_req, 0);
    rst_n = 1;
    @(negedge clk);
    txn(3, 1, 0, 0, 1, 'h0010, 'hFF, 0);          // R2 byte wrap to zero, R8
    txn(3, 0, 0, 0, 1, 'h0011, 'hFF, 0);          // R8 non-count level
    txn(2, 0, 0, 0, 1, 'h0012, 'h7F, 0);          // R2 sign boundary
    txn(5, 0, 0, 1, -2, 'h0020, 'h1234, 0);       // R3 R4 halfword
    txn(5, 1, 0, 1, -1, 'h0022, 'h0000, 0);       // R4 halfword underflow
    txn(6, 1, 0, 2, 1, 'h0030, 'hFFFF_FFFF, 0);   // R3 word wrap, R8
    txn(6, 0, 0, 2, -128, 'h0034, 'h10, 0);       // R4 word negative
    txn(4, 0, 1, 0, 3, 'h0050, 'h10, 0);          // R6 mapped
    txn(4, 0, 0, 0, 3, 'h0051, 'h10, 0);          // R6 map disabled
    txn(2, 0, 1, 0, 3, 'h0052, 'h10, 0);          // R5 other level, map on
    txn(1, 1, 0, 0, -1, 'h0060, 'h01, 1);         // R10 held activation
    reject(8'h34, 2'b00);                         // R9 other opcode
    reject(8'h33, 2'b11);                         // R9 bad size
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1;
      nchk++; nerr++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule